// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between interrupt source controllers and a single processor. It holds the processor's current priority, at most one pending interrupt (a source number plus its priority), and a software-written priority for an inter-processor interrupt. Source controllers offer interrupts as a source number with a priority. The presenter keeps the offer if it is more favoured than everything it already holds. Otherwise it bounces the offer back. When a better offer arrives, the presenter hands back the interrupt it had kept. The interrupt line to the processor is high while an interrupt is pending.

The processor reaches the block through a small operation port. It can accept the pending interrupt, which is a read with side effects. It can poll, which is a read without side effects. It can also write its current priority, write the inter-processor priority, or signal end of interrupt. A lower numeric priority is more favoured, and the all-ones priority means "none". The readable word carries the processor priority in bits 31:24 and the pending source number in bits 23:0. Source number 0 means nothing is pending, and source number 2 is reserved for the inter-processor interrupt.

Offers and operations must not arrive in the same cycle. Every result appears on registered outputs on the clock edge that takes the request in. The bounce, end-of-interrupt and resend outputs are single-cycle pulses.

Top module: `intr_presenter`

## Requirements
- R1: After reset, the readable word is 0, the inter-processor priority is 0xFF, the pending priority is 0xFF and the interrupt line is low.
- R2: A poll (op code 2) returns {processor priority[31:24], pending source[23:0]} on rd_data and the inter-processor priority on rd_ipi. It changes no state.
- R3: An offer is bounced (rej_valid with rej_src equal to the offered source) when its priority is greater than or equal to the processor priority. It is also bounced when a source is pending whose priority is less than or equal to the offered one. A bounced offer leaves the held state unchanged.
- R4: A kept offer stores its source and priority and raises the line. If an external source was pending, that older source is bounced in the same cycle.
- R5: An accept (op code 1) returns the word as it was before the accept and lowers the line. The processor priority takes the old pending priority, the source field becomes 0 and the pending priority becomes 0xFF.
- R6: Writing a processor priority (op code 3, value in bits 31:24) that is lower than the old one cancels the pending interrupt only when the new value is less than or equal to the pending priority. Cancelling clears the source, lowers the line and bounces an external source. If that condition does not hold, nothing else changes and no resend is requested.
- R7: Writing a processor priority equal to or higher than the old one while nothing is pending pulses resend_req. In that case, if the inter-processor priority is below the new processor priority, source 2 is installed at that priority and the line rises.
- R8: Writing the inter-processor priority (op code 4, value in bits 7:0) below the processor priority installs source 2 at that priority, raises the line and bounces any external pending source. This does not happen when a pending priority is already less than or equal to the written value, in which case the held interrupt stays.
- R9: Writing an inter-processor priority that is not below the processor priority only stores it.
- R10: An end of interrupt (op code 5) loads bits 31:24 into the processor priority and pulses eoi_valid with eoi_src equal to bits 23:0. If nothing is pending, it pulses resend_req and re-checks the inter-processor interrupt as in R7.
- R11: A pending inter-processor interrupt that is displaced or cancelled is never bounced on rej_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | Offer from a source controller this cycle (never together with op_valid) |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| op_valid | input | 1 | Processor operation this cycle |
| op_code | input | 3 | 1 accept, 2 poll, 3 set priority, 4 set inter-processor priority, 5 end of interrupt |
| op_wdata | input | 32 | Write value for codes 3 to 5 |
| rd_valid | output | 1 | Read result valid (codes 1 and 2) |
| rd_data | output | 32 | Readable word returned by a read |
| rd_ipi | output | 8 | Inter-processor priority returned by a read |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Bounce pulse to the source side |
| rej_src | output | 24 | Bounced source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source side |
| eoi_src | output | 24 | Source number of the end of interrupt |
| resend_req | output | 1 | Resend request pulse to the source side |

## Verification
Every offer and every operation is resolved on the edge that takes it in. The read data, bounce, end-of-interrupt, resend and line outputs are therefore due exactly one edge later, and the pulses last only that cycle. The bench drives each request on a falling edge and samples every output on the next falling edge. It then drops the request, so each pulse is seen in the one cycle it exists. Held state that has no port of its own, such as the processor priority, the pending source and the inter-processor priority, is read back by a poll. The pending priority is read back through the processor priority an accept leaves behind.

// File: rtl/ipres_pkg.sv
package ipres_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_ACCEPT   = 3'd1,
        OP_POLL     = 3'd2,
        OP_SET_CPRI = 3'd3,
        OP_SET_IPI  = 3'd4,
        OP_EOI      = 3'd5
    } op_e;

    // verdict on an external offer
    typedef struct packed {
        logic take;        // offer becomes the pending interrupt
        logic bounce_new;  // offer goes back to its source
        logic bounce_old;  // displaced external source goes back
    } offer_verdict_t;

    // verdict of an inter-processor evaluation
    typedef struct packed {
        logic install;     // reserved source takes the pending slot
        logic bounce_old;  // displaced external source goes back
    } ipi_verdict_t;

    // lower numeric value is the more favoured priority
    function automatic logic favoured(input logic [7:0] a, input logic [7:0] b);
        return a < b;
    endfunction

endpackage

// File: rtl/ipres_offer_arb.sv
module ipres_offer_arb
    import ipres_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              offer_valid,
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic [PRIO_W-1:0] cur_cpri,
    input  logic              pend_valid,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              pend_ipi,
    output offer_verdict_t    verdict
);
    logic beats_cpu;
    logic beats_pending;

    always_comb begin
        beats_cpu          = offer_prio < cur_cpri;
        beats_pending      = !pend_valid || (offer_prio < pend_prio);
        verdict.take       = offer_valid && beats_cpu && beats_pending;
        verdict.bounce_new = offer_valid && !verdict.take;
        verdict.bounce_old = verdict.take && pend_valid && !pend_ipi;
    end

endmodule

// File: rtl/ipres_ipi_check.sv
module ipres_ipi_check
    import ipres_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              enable,
    input  logic [PRIO_W-1:0] ipi_val,
    input  logic [PRIO_W-1:0] bound,
    input  logic              pend_valid,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              pend_ipi,
    output ipi_verdict_t      verdict
);
    logic fire;
    logic held_wins;

    always_comb begin
        fire               = enable && (ipi_val < bound);
        held_wins          = pend_valid && (pend_prio <= ipi_val);
        verdict.install    = fire && !held_wins;
        verdict.bounce_old = verdict.install && pend_valid && !pend_ipi;
    end

endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
    import ipres_pkg::*;
#(
    parameter int          SRC_W   = 24,
    parameter int          PRIO_W  = 8,
    parameter int unsigned IPI_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     offer_valid,
    input  logic [SRC_W-1:0]         offer_src,
    input  logic [PRIO_W-1:0]        offer_prio,
    input  logic                     op_valid,
    input  logic [2:0]               op_code,
    input  logic [SRC_W+PRIO_W-1:0]  op_wdata,
    output logic                     rd_valid,
    output logic [SRC_W+PRIO_W-1:0]  rd_data,
    output logic [PRIO_W-1:0]        rd_ipi,
    output logic                     irq_out,
    output logic                     rej_valid,
    output logic [SRC_W-1:0]         rej_src,
    output logic                     eoi_valid,
    output logic [SRC_W-1:0]         eoi_src,
    output logic                     resend_req
);
    localparam int                REG_W     = SRC_W + PRIO_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  IPI_TAG   = SRC_W'(IPI_SRC);

    // held state
    logic [PRIO_W-1:0] cur_cpri, pend_prio, ipi_prio;
    logic [SRC_W-1:0]  pend_src;
    logic              pend_ipi;

    // next state
    logic [PRIO_W-1:0] n_cpri, n_pprio, n_ipi;
    logic [SRC_W-1:0]  n_src;
    logic              n_pipi;
    logic              n_rd_v, n_rej_v, n_eoi_v, n_resend;
    logic [REG_W-1:0]  n_rd_d;
    logic [PRIO_W-1:0] n_rd_ipi;
    logic [SRC_W-1:0]  n_rej_s, n_eoi_s;

    op_e               op;
    logic              pend_valid;
    logic [PRIO_W-1:0] w_cpri, w_ipi;
    logic [SRC_W-1:0]  w_src;
    logic [REG_W-1:0]  cur_word;

    logic              ipi_en;
    logic [PRIO_W-1:0] ipi_val, ipi_bound;
    offer_verdict_t    ov;
    ipi_verdict_t      iv;

    assign op         = op_e'(op_code);
    assign pend_valid = (pend_src != '0);
    assign w_cpri     = op_wdata[REG_W-1:SRC_W];
    assign w_ipi      = op_wdata[PRIO_W-1:0];
    assign w_src      = op_wdata[SRC_W-1:0];
    assign cur_word   = {cur_cpri, pend_src};

    ipres_offer_arb #(.PRIO_W(PRIO_W)) u_arb (
        .offer_valid (offer_valid && !op_valid),
        .offer_prio  (offer_prio),
        .cur_cpri    (cur_cpri),
        .pend_valid  (pend_valid),
        .pend_prio   (pend_prio),
        .pend_ipi    (pend_ipi),
        .verdict     (ov)
    );

    // the IPI path is evaluated against the priority bound the operation leaves
    always_comb begin
        ipi_en    = 1'b0;
        ipi_val   = ipi_prio;
        ipi_bound = cur_cpri;
        if (op_valid) begin
            unique case (op)
                OP_SET_IPI: begin
                    ipi_en  = 1'b1;
                    ipi_val = w_ipi;
                end
                OP_SET_CPRI: begin
                    ipi_en    = (w_cpri >= cur_cpri) && !pend_valid;
                    ipi_bound = w_cpri;
                end
                OP_EOI: begin
                    ipi_en    = !pend_valid;
                    ipi_bound = w_cpri;
                end
                default: ;
            endcase
        end
    end

    ipres_ipi_check #(.PRIO_W(PRIO_W)) u_ipi (
        .enable     (ipi_en),
        .ipi_val    (ipi_val),
        .bound      (ipi_bound),
        .pend_valid (pend_valid),
        .pend_prio  (pend_prio),
        .pend_ipi   (pend_ipi),
        .verdict    (iv)
    );

    always_comb begin
        n_cpri   = cur_cpri;
        n_pprio  = pend_prio;
        n_ipi    = ipi_prio;
        n_src    = pend_src;
        n_pipi   = pend_ipi;
        n_rd_v   = 1'b0;
        n_rd_d   = rd_data;
        n_rd_ipi = rd_ipi;
        n_rej_v  = 1'b0;
        n_rej_s  = '0;
        n_eoi_v  = 1'b0;
        n_eoi_s  = '0;
        n_resend = 1'b0;

        if (op_valid) begin
            unique case (op)
                OP_ACCEPT: begin
                    n_rd_v   = 1'b1;
                    n_rd_d   = cur_word;
                    n_rd_ipi = ipi_prio;
                    n_cpri   = pend_prio;
                    n_src    = '0;
                    n_pprio  = PRIO_NONE;
                    n_pipi   = 1'b0;
                end
                OP_POLL: begin
                    n_rd_v   = 1'b1;
                    n_rd_d   = cur_word;
                    n_rd_ipi = ipi_prio;
                end
                OP_SET_CPRI: begin
                    n_cpri = w_cpri;
                    if (w_cpri < cur_cpri) begin
                        if (pend_valid && (w_cpri <= pend_prio)) begin
                            n_src   = '0;
                            n_pprio = PRIO_NONE;
                            n_pipi  = 1'b0;
                            if (!pend_ipi) begin
                                n_rej_v = 1'b1;
                                n_rej_s = pend_src;
                            end
                        end
                    end else if (!pend_valid) begin
                        n_resend = 1'b1;
                    end
                end
                OP_SET_IPI: begin
                    n_ipi = w_ipi;
                end
                OP_EOI: begin
                    n_cpri  = w_cpri;
                    n_eoi_v = 1'b1;
                    n_eoi_s = w_src;
                    if (!pend_valid) n_resend = 1'b1;
                end
                default: ;
            endcase
            if (iv.install) begin
                n_src   = IPI_TAG;
                n_pprio = ipi_val;
                n_pipi  = 1'b1;
            end
            if (iv.bounce_old) begin
                n_rej_v = 1'b1;
                n_rej_s = pend_src;
            end
        end else begin
            if (ov.take) begin
                n_src   = offer_src;
                n_pprio = offer_prio;
                n_pipi  = 1'b0;
            end
            if (ov.bounce_old) begin
                n_rej_v = 1'b1;
                n_rej_s = pend_src;
            end
            if (ov.bounce_new) begin
                n_rej_v = 1'b1;
                n_rej_s = offer_src;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cpri   <= '0;
            pend_prio  <= PRIO_NONE;
            ipi_prio   <= PRIO_NONE;
            pend_src   <= '0;
            pend_ipi   <= 1'b0;
            irq_out    <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            rd_ipi     <= '0;
            rej_valid  <= 1'b0;
            rej_src    <= '0;
            eoi_valid  <= 1'b0;
            eoi_src    <= '0;
            resend_req <= 1'b0;
        end else begin
            cur_cpri   <= n_cpri;
            pend_prio  <= n_pprio;
            ipi_prio   <= n_ipi;
            pend_src   <= n_src;
            pend_ipi   <= n_pipi;
            irq_out    <= (n_src != '0);
            rd_valid   <= n_rd_v;
            rd_data    <= n_rd_d;
            rd_ipi     <= n_rd_ipi;
            rej_valid  <= n_rej_v;
            rej_src    <= n_rej_s;
            eoi_valid  <= n_eoi_v;
            eoi_src    <= n_eoi_s;
            resend_req <= n_resend;
        end
    end

endmodule

// File: rtl/ipres_chk.sv
module ipres_chk
    import ipres_pkg::*;
#(
    parameter int SRC_W  = 24,
    parameter int PRIO_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    offer_valid,
    input logic [SRC_W-1:0]        offer_src,
    input logic [PRIO_W-1:0]       offer_prio,
    input logic                    op_valid,
    input logic [2:0]              op_code,
    input logic [SRC_W+PRIO_W-1:0] op_wdata,
    input logic                    rd_valid,
    input logic [SRC_W+PRIO_W-1:0] rd_data,
    input logic                    irq_out,
    input logic                    rej_valid,
    input logic [SRC_W-1:0]        rej_src,
    input logic                    eoi_valid,
    input logic [SRC_W-1:0]        eoi_src,
    input logic [PRIO_W-1:0]       cur_cpri,
    input logic [SRC_W-1:0]        pend_src,
    input logic [PRIO_W-1:0]       pend_prio,
    input logic [PRIO_W-1:0]       ipi_prio
);
    localparam int REG_W = SRC_W + PRIO_W;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cur_cpri == '0 && pend_src == '0 && pend_prio == '1
                        && ipi_prio == '1 && !irq_out));

    assert_poll_still_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_POLL) |=>
            (rd_valid && rd_data == $past({cur_cpri, pend_src})
             && $stable(cur_cpri) && $stable(pend_src) && $stable(pend_prio)));

    assert_low_offer_bounced_R3: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && !op_valid && offer_prio >= cur_cpri) |=>
            (rej_valid && rej_src == $past(offer_src) && $stable(pend_src)));

    assert_line_follows_pending_R4: assert property (@(posedge clk) disable iff (rst)
        irq_out == (pend_src != '0));

    assert_accept_drops_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_ACCEPT) |=>
            (!irq_out && pend_src == '0 && cur_cpri == $past(pend_prio)));

    assert_ipi_stored_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_SET_IPI) |=> ipi_prio == $past(op_wdata[PRIO_W-1:0]));

    assert_eoi_forward_R10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_EOI) |=>
            (eoi_valid && eoi_src == $past(op_wdata[SRC_W-1:0])
             && cur_cpri == $past(op_wdata[REG_W-1:SRC_W])));

endmodule

bind intr_presenter ipres_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .offer_valid (offer_valid),
    .offer_src   (offer_src),
    .offer_prio  (offer_prio),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .op_wdata    (op_wdata),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .irq_out     (irq_out),
    .rej_valid   (rej_valid),
    .rej_src     (rej_src),
    .eoi_valid   (eoi_valid),
    .eoi_src     (eoi_src),
    .cur_cpri    (cur_cpri),
    .pend_src    (pend_src),
    .pend_prio   (pend_prio),
    .ipi_prio    (ipi_prio)
);

// File: tb/tb_intr_presenter.sv
`timescale 1ns/1ps
module tb_intr_presenter;
    logic        clk = 1'b0;
    logic        rst;
    logic        offer_valid;
    logic [23:0] offer_src;
    logic [7:0]  offer_prio;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [31:0] op_wdata;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [7:0]  rd_ipi;
    logic        irq_out;
    logic        rej_valid;
    logic [23:0] rej_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_req;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    // captured outputs of the last request
    logic        s_rdv, s_irq, s_rejv, s_eoiv, s_res;
    logic [31:0] s_rd;
    logic [7:0]  s_ipi;
    logic [23:0] s_rej, s_eoi;

    localparam logic [2:0] C_ACC = 3'd1, C_POLL = 3'd2, C_CPRI = 3'd3,
                           C_IPI = 3'd4, C_EOI  = 3'd5;

    always #10 clk = ~clk;

    intr_presenter dut (
        .clk(clk), .rst(rst),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .op_valid(op_valid), .op_code(op_code), .op_wdata(op_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ipi(rd_ipi),
        .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic capture();
        s_rdv  = rd_valid;  s_rd  = rd_data;  s_ipi = rd_ipi;
        s_irq  = irq_out;   s_rejv = rej_valid; s_rej = rej_src;
        s_eoiv = eoi_valid; s_eoi = eoi_src;  s_res = resend_req;
    endtask

    // called at a falling edge; returns at the next falling edge with outputs captured
    task automatic do_op(input logic [2:0] code, input logic [31:0] wd);
        op_valid = 1'b1; op_code = code; op_wdata = wd;
        @(negedge clk);
        capture();
        op_valid = 1'b0; op_code = 3'd0; op_wdata = '0;
    endtask

    task automatic do_offer(input logic [23:0] src, input logic [7:0] prio);
        offer_valid = 1'b1; offer_src = src; offer_prio = prio;
        @(negedge clk);
        capture();
        offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
    endtask

    task automatic poll_expect(input string tag, input logic [31:0] word);
        do_op(C_POLL, 32'h0);
        chk({tag, " poll word"}, s_rd, word);
    endtask

    task automatic t_reset();
        do_op(C_POLL, 32'h0);
        chk("R1 word", s_rd, 32'h0);
        chk("R1 ipi", {24'h0, s_ipi}, 32'hFF);
        chk("R1 line", {31'h0, s_irq}, 32'h0);
        chk("R2 rd_valid", {31'h0, s_rdv}, 32'h1);
    endtask

    task automatic t_offer_paths();
        do_offer(24'h10, 8'h05);
        chk("R3 bounce at prio 0", {7'h0, s_rejv, s_rej}, {8'h1, 24'h10});
        chk("R3 line", {31'h0, s_irq}, 32'h0);
        do_op(C_CPRI, 32'hFF00_0000);
        chk("R7 resend", {31'h0, s_res}, 32'h1);
        chk("R7 no ipi", {31'h0, s_irq}, 32'h0);
        do_offer(24'h21, 8'h08);
        chk("R4 kept", {30'h0, s_rejv, s_irq}, 32'h1);
        poll_expect("R4", 32'hFF00_0021);
        poll_expect("R2 repeat", 32'hFF00_0021);
        do_offer(24'h30, 8'h08);
        chk("R3 equal pending", {7'h0, s_rejv, s_rej}, {8'h1, 24'h30});
        poll_expect("R3", 32'hFF00_0021);
        do_offer(24'h31, 8'h03);
        chk("R4 displace", {7'h0, s_rejv, s_rej}, {8'h1, 24'h21});
        poll_expect("R4 displace", 32'hFF00_0031);
    endtask

    task automatic t_accept_eoi();
        do_op(C_ACC, 32'h0);
        chk("R5 value", s_rd, 32'hFF00_0031);
        chk("R5 line", {31'h0, s_irq}, 32'h0);
        poll_expect("R5", 32'h0300_0000);
        do_op(C_EOI, 32'hFF00_0031);
        chk("R10 eoi", {7'h0, s_eoiv, s_eoi}, {8'h1, 24'h31});
        chk("R10 resend", {31'h0, s_res}, 32'h1);
        chk("R10 no ipi", {31'h0, s_irq}, 32'h0);
        poll_expect("R10", 32'hFF00_0000);
    endtask

    task automatic t_ipi_paths();
        do_op(C_IPI, 32'h40);
        chk("R8 install", {30'h0, s_rejv, s_irq}, 32'h1);
        do_op(C_POLL, 32'h0);
        chk("R8 word", s_rd, 32'hFF00_0002);
        chk("R8 ipi", {24'h0, s_ipi}, 32'h40);
        do_offer(24'h50, 8'h20);
        chk("R11 ipi displaced silently", {30'h0, s_rejv, s_irq}, 32'h1);
        poll_expect("R11", 32'hFF00_0050);
        do_op(C_IPI, 32'h10);
        chk("R8 bounce external", {7'h0, s_rejv, s_rej}, {8'h1, 24'h50});
        poll_expect("R8", 32'hFF00_0002);
        do_op(C_IPI, 32'h30);
        chk("R8 held wins", {31'h0, s_rejv}, 32'h0);
        do_op(C_POLL, 32'h0);
        chk("R8 held word", s_rd, 32'hFF00_0002);
        chk("R8 ipi stored", {24'h0, s_ipi}, 32'h30);
    endtask

    task automatic t_cancel_resend();
        do_op(C_CPRI, 32'h1000_0000);
        chk("R11 cancel ipi no bounce", {30'h0, s_rejv, s_irq}, 32'h0);
        poll_expect("R6 cancel", 32'h1000_0000);
        do_op(C_IPI, 32'h20);
        chk("R9 line", {31'h0, s_irq}, 32'h0);
        do_op(C_POLL, 32'h0);
        chk("R9 word", s_rd, 32'h1000_0000);
        chk("R9 ipi", {24'h0, s_ipi}, 32'h20);
        do_op(C_CPRI, 32'h8000_0000);
        chk("R7 resend+ipi", {30'h0, s_res, s_irq}, 32'h3);
        poll_expect("R7", 32'h8000_0002);
        do_op(C_ACC, 32'h0);
        chk("R5 ipi accept", s_rd, 32'h8000_0002);
        poll_expect("R5 ipi", 32'h2000_0000);
        do_op(C_IPI, 32'hFF);
        do_op(C_CPRI, 32'hFF00_0000);
        chk("R7 resend only", {30'h0, s_res, s_irq}, 32'h2);
        do_offer(24'h60, 8'h40);
        do_op(C_CPRI, 32'h4000_0000);
        chk("R6 cancel external", {6'h0, s_irq, s_rejv, s_rej}, {8'h1, 24'h60});
        poll_expect("R6", 32'h4000_0000);
        do_op(C_CPRI, 32'h2000_0000);
        chk("R6 no pend no resend", {29'h0, s_res, s_rejv, s_irq}, 32'h0);
        do_op(C_CPRI, 32'hFF00_0000);
        do_offer(24'h70, 8'h50);
        do_op(C_CPRI, 32'h6000_0000);
        chk("R6 keep", {30'h0, s_rejv, s_irq}, 32'h1);
        poll_expect("R6 keep", 32'h6000_0070);
    endtask

    task automatic t_eoi_recheck();
        do_op(C_EOI, 32'hFF00_0123);
        chk("R10 eoi pending", {7'h0, s_eoiv, s_eoi}, {8'h1, 24'h123});
        chk("R10 no resend", {31'h0, s_res}, 32'h0);
        poll_expect("R10 pending", 32'hFF00_0070);
        do_op(C_ACC, 32'h0);
        chk("R5 second", s_rd, 32'hFF00_0070);
        do_op(C_IPI, 32'h60);
        chk("R9 not below", {31'h0, s_irq}, 32'h0);
        do_op(C_EOI, 32'hFF00_0070);
        chk("R10 resend+ipi", {30'h0, s_res, s_irq}, 32'h3);
        poll_expect("R10 ipi", 32'hFF00_0002);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
        op_valid = 1'b0; op_code = '0; op_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_offer_paths();
        t_accept_eoi();
        t_ipi_paths();
        t_cancel_resend();
        t_eoi_recheck();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule